// File: doc/BRIEF.md
# Privileged Interrupt Priority Selector

This block decides which local interrupt cause a hart should take next. Each cycle it takes a vector of pending causes and a vector of per-cause enable bits. It also takes a delegation mask that marks causes handed down to the supervisor level, the hart's current privilege level, and the machine and supervisor global enable bits. From these it reports whether an interrupt should be taken and, if so, the number of the chosen cause.

Every pending and enabled cause is first checked against the enable rule of the level that would handle it. Undelegated causes are handled at machine level and delegated causes at supervisor level. A cause may interrupt a hart running below its handling level at any time. It may interrupt a hart running at that same level only when that level's global enable is set. Of the causes that survive, the lowest-numbered one wins. A parameter chooses between a purely combinational result and one that passes through a single register stage.

Top module: `irq_prio_select`

## Requirements
- R1: A cause is a candidate only when its bit is set in both `pend_i` and `en_i`.
- R2: A cause whose `deleg_i` bit is 0 may be selected when the current level is below machine level (encodings 0, 1, 2). At machine level (encoding 3) it may be selected only with `m_gie_i` = 1.
- R3: A cause whose `deleg_i` bit is 1 may be selected when the current level is user (encoding 0 or 2), or supervisor (encoding 1) with `s_gie_i` = 1. It is never selected at machine level.
- R4: When several candidates survive gating, `irq_idx_o` is the lowest bit index among them.
- R5: When no candidate survives, `irq_valid_o` is 0 and `irq_idx_o` is 0.
- R6: `priv_i` encodes user as 0, supervisor as 1 and machine as 3. Encoding 2 behaves exactly as user.
- R7: With `REG_OUT` = 1 (default), `irq_valid_o` and `irq_idx_o` are the result for the inputs present at the previous rising clock edge. The registered result is updated on every edge.
- R8: While `rst_n` is 0 at a rising edge, the registered outputs become `irq_valid_o` = 0 and `irq_idx_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 16 | Pending cause vector |
| en_i | input | 16 | Per-cause enable vector |
| deleg_i | input | 16 | Delegation mask, 1 = cause handled at supervisor level |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 2 user, 3 machine) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| irq_valid_o | output | 1 | An interrupt should be taken |
| irq_idx_o | output | 4 | Number of the selected cause (0 when no interrupt) |

## Verification
With the default registered output, every result appears exactly one rising edge after the inputs that produce it. The bench drives a new input set at a falling edge and compares both outputs at the following falling edge. By then the single register stage has captured that set and nothing else. A reset asserted at a falling edge takes effect at the next rising edge, so the cleared outputs are checked at the falling edge after that. Directed cases cover each gating rule and the encoding-2 alias. A long sweep of random vectors at all four level encodings is compared against a loop-based reference kept in the bench.

// File: rtl/irq_sel_pkg.sv
// Package: shared privilege encoding and helpers for the interrupt selector.
// Assumes the two-bit level encoding user=0, supervisor=1, machine=3, with
// the unused value 2 folded onto user.
package irq_sel_pkg;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } priv_lvl_e;

    // Fold the unused encoding onto user level.
    function automatic priv_lvl_e norm_level(input logic [1:0] raw);
        priv_lvl_e lvl;
        lvl = priv_lvl_e'(raw);
        if (lvl == LVL_RSVD) begin
            lvl = LVL_USER;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/irq_gate.sv
// Module: irq_gate
// Masks the pending vector down to the causes that may interrupt the hart
// right now. A cause must be pending and enabled. It must also pass the enable
// rule of the level that handles it: machine level for undelegated causes and
// supervisor level for delegated ones.
// Assumes: purely combinational; priv_i uses the package encoding.
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int unsigned NUM_CAUSES = 16
) (
    input  logic [NUM_CAUSES-1:0] pend_i,
    input  logic [NUM_CAUSES-1:0] en_i,
    input  logic [NUM_CAUSES-1:0] deleg_i,
    input  logic [1:0]            priv_i,
    input  logic                  m_gie_i,
    input  logic                  s_gie_i,
    output logic [NUM_CAUSES-1:0] cand_o
);

    priv_lvl_e             lvl;
    logic                  m_open;
    logic                  s_open;
    logic [NUM_CAUSES-1:0] armed;

    // Decide per handling level whether it is open to interrupts now.
    always_comb begin
        lvl    = norm_level(priv_i);
        m_open = (lvl != LVL_MACH) || m_gie_i;
        s_open = (lvl == LVL_USER) || ((lvl == LVL_SUPER) && s_gie_i);
    end

    // Combine pending/enable with the level each cause is routed to.
    always_comb begin
        armed  = pend_i & en_i;
        cand_o = (armed & ~deleg_i & {NUM_CAUSES{m_open}})
               | (armed &  deleg_i & {NUM_CAUSES{s_open}});
    end

endmodule

// File: rtl/irq_lsb_pick.sv
// Module: irq_lsb_pick
// Finds the lowest set bit of the candidate vector and reports it with a
// valid flag. The index is forced to 0 when no bit is set.
// Assumes: purely combinational; NUM_CAUSES >= 2.
module irq_lsb_pick #(
    parameter int unsigned NUM_CAUSES = 16,
    localparam int unsigned IDX_W     = $clog2(NUM_CAUSES)
) (
    input  logic [NUM_CAUSES-1:0] cand_i,
    output logic                  valid_o,
    output logic [IDX_W-1:0]      idx_o
);

    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        valid_o = |cand_i;
        idx_o   = '0;
        for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_out_stage.sv
// Module: irq_out_stage
// Optionally registers the selection. With REG_OUT=1 it adds one cycle of
// latency and a synchronous active-low reset that clears the result. With
// REG_OUT=0 it passes the result straight through.
module irq_out_stage #(
    parameter int unsigned IDX_W   = 4,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    generate
        if (REG_OUT) begin : g_reg
            logic             valid_q;
            logic [IDX_W-1:0] idx_q;

            // Capture the selection each cycle; reset clears it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    idx_q   <= '0;
                end else begin
                    valid_q <= valid_i;
                    idx_q   <= idx_i;
                end
            end

            assign valid_o = valid_q;
            assign idx_o   = idx_q;

            // R7: registered output carries the previous cycle's selection.
            a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (valid_o == $past(valid_i)) && (idx_o == $past(idx_i)));
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign valid_o    = valid_i;
            assign idx_o      = idx_i;
        end
    endgenerate

endmodule

// File: rtl/irq_prio_select.sv
// Module: irq_prio_select (top)
// Chooses the local interrupt cause a hart should take. Pending causes are
// gated by enable, delegation and the current level's global enables. The
// lowest-numbered survivor is then reported, optionally through one register.
// Assumes: synchronous active-low reset; inputs stable around the clock edge.
module irq_prio_select #(
    parameter int unsigned NUM_CAUSES = 16,
    parameter bit          REG_OUT    = 1'b1,
    localparam int unsigned IDX_W     = $clog2(NUM_CAUSES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CAUSES-1:0] pend_i,
    input  logic [NUM_CAUSES-1:0] en_i,
    input  logic [NUM_CAUSES-1:0] deleg_i,
    input  logic [1:0]            priv_i,
    input  logic                  m_gie_i,
    input  logic                  s_gie_i,
    output logic                  irq_valid_o,
    output logic [IDX_W-1:0]      irq_idx_o
);

    localparam logic [NUM_CAUSES-1:0] ONE_V = NUM_CAUSES'(1);

    logic [NUM_CAUSES-1:0] cand;
    logic                  sel_valid;
    logic [IDX_W-1:0]      sel_idx;

    irq_gate #(.NUM_CAUSES(NUM_CAUSES)) u_gate (
        .pend_i  (pend_i),
        .en_i    (en_i),
        .deleg_i (deleg_i),
        .priv_i  (priv_i),
        .m_gie_i (m_gie_i),
        .s_gie_i (s_gie_i),
        .cand_o  (cand)
    );

    irq_lsb_pick #(.NUM_CAUSES(NUM_CAUSES)) u_pick (
        .cand_i  (cand),
        .valid_o (sel_valid),
        .idx_o   (sel_idx)
    );

    irq_out_stage #(.IDX_W(IDX_W), .REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (sel_valid),
        .idx_i   (sel_idx),
        .valid_o (irq_valid_o),
        .idx_o   (irq_idx_o)
    );

    // R1: the chosen cause is pending and enabled.
    a_r1_pend_and_en: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> pend_i[sel_idx] && en_i[sel_idx]);

    // R2: an undelegated choice at machine level needs the machine enable.
    a_r2_mach_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !deleg_i[sel_idx]) |-> (priv_i != 2'd3) || m_gie_i);

    // R3: a delegated choice needs user level or supervisor with its enable.
    a_r3_super_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && deleg_i[sel_idx]) |->
            (priv_i == 2'd0) || (priv_i == 2'd2) || ((priv_i == 2'd1) && s_gie_i));

    // R4: no candidate below the chosen index.
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (cand & ((ONE_V << sel_idx) - ONE_V)) == '0);

    // R5: an empty selection reports index zero and no candidate exists.
    a_r5_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (sel_idx == '0) && (cand == '0));

endmodule

// File: tb/test_irq_prio_select.sv
// Bench for irq_prio_select: drives inputs on falling edges and compares
// outputs one falling edge later against a loop-based reference model.
module test_irq_prio_select;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pend_i = '0;
    logic [N-1:0] en_i = '0;
    logic [N-1:0] deleg_i = '0;
    logic [1:0]   priv_i = 2'd0;
    logic         m_gie_i = 1'b0;
    logic         s_gie_i = 1'b0;
    logic         irq_valid_o;
    logic [3:0]   irq_idx_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_prio_select i_irq_prio_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend_i),
        .en_i        (en_i),
        .deleg_i     (deleg_i),
        .priv_i      (priv_i),
        .m_gie_i     (m_gie_i),
        .s_gie_i     (s_gie_i),
        .irq_valid_o (irq_valid_o),
        .irq_idx_o   (irq_idx_o)
    );

    // Reference: returns -1 for no interrupt, else the winning cause.
    function automatic int ref_pick(input logic [N-1:0] p, input logic [N-1:0] e,
                                    input logic [N-1:0] d, input logic [1:0] pr,
                                    input logic mg, input logic sg);
        int lvl;
        bit ok;
        lvl = (pr == 2'd2) ? 0 : int'(pr);
        for (int i = 0; i < N; i++) begin
            if (p[i] && e[i]) begin
                if (d[i]) ok = (lvl == 0) || (lvl == 1 && sg);
                else      ok = (lvl < 3) || mg;
                if (ok) return i;
            end
        end
        return -1;
    endfunction

    task automatic compare(input string tag, input int exp);
        logic       ev;
        logic [3:0] ei;
        ev = (exp >= 0);
        ei = ev ? 4'(exp) : 4'd0;
        checks++;
        if (irq_valid_o !== ev || irq_idx_o !== ei) begin
            fails++;
            $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
                     tag, irq_valid_o, irq_idx_o, ev, ei);
        end
    endtask

    // Apply one input set at a falling edge; check it at the next falling edge.
    task automatic step(input string tag, input logic [N-1:0] p, input logic [N-1:0] e,
                        input logic [N-1:0] d, input logic [1:0] pr,
                        input logic mg, input logic sg);
        int exp;
        pend_i = p; en_i = e; deleg_i = d; priv_i = pr; m_gie_i = mg; s_gie_i = sg;
        exp = ref_pick(p, e, d, pr, mg, sg);
        @(negedge clk);
        compare(tag, exp);
    endtask

    initial begin
        #(5ns * 20000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R8: reset state with live inputs present.
        pend_i = 16'hFFFF; en_i = 16'hFFFF; priv_i = 2'd0;
        repeat (3) @(negedge clk);
        compare("R8 reset state", -1);
        rst_n = 1'b1;

        // R1: pending without enable, enable without pending.
        step("R1 pend no en", 16'h0010, 16'h0000, 16'h0, 2'd0, 1'b0, 1'b0);
        step("R1 en no pend", 16'h0000, 16'h0010, 16'h0, 2'd0, 1'b0, 1'b0);
        step("R1 both set",   16'h0010, 16'h0010, 16'h0, 2'd0, 1'b0, 1'b0);
        // R2: undelegated cause versus machine enable.
        step("R2 M no mie",   16'h0080, 16'h0080, 16'h0, 2'd3, 1'b0, 1'b1);
        step("R2 M mie",      16'h0080, 16'h0080, 16'h0, 2'd3, 1'b1, 1'b0);
        step("R2 S any mie",  16'h0080, 16'h0080, 16'h0, 2'd1, 1'b0, 1'b0);
        // R3: delegated cause rules.
        step("R3 M never",    16'h0200, 16'h0200, 16'h0200, 2'd3, 1'b1, 1'b1);
        step("R3 S no sie",   16'h0200, 16'h0200, 16'h0200, 2'd1, 1'b1, 1'b0);
        step("R3 S sie",      16'h0200, 16'h0200, 16'h0200, 2'd1, 1'b0, 1'b1);
        step("R3 U always",   16'h0200, 16'h0200, 16'h0200, 2'd0, 1'b0, 1'b0);
        // R4: lowest surviving index wins, including a gated-off lower bit.
        step("R4 lowest",     16'h1088, 16'hFFFF, 16'h0, 2'd0, 1'b0, 1'b0);
        step("R4 gated low",  16'h1088, 16'hFFFF, 16'h0008, 2'd1, 1'b0, 1'b0);
        step("R4 bit15",      16'h8000, 16'h8000, 16'h0, 2'd3, 1'b1, 1'b0);
        step("R4 bit0",       16'hFFFF, 16'hFFFF, 16'h0, 2'd3, 1'b1, 1'b0);
        // R5: nothing survives -> index zero.
        step("R5 none",       16'h0F00, 16'h00F0, 16'h0, 2'd3, 1'b1, 1'b1);
        // R6: encoding 2 acts as user.
        step("R6 lvl2 deleg", 16'h0040, 16'h0040, 16'h0040, 2'd2, 1'b0, 1'b0);
        step("R6 lvl2 undel", 16'h0040, 16'h0040, 16'h0000, 2'd2, 1'b0, 1'b0);
        // R7: back-to-back changes show one-cycle latency every cycle.
        step("R7 seq a",      16'h0004, 16'h0004, 16'h0, 2'd0, 1'b0, 1'b0);
        step("R7 seq b",      16'h0000, 16'h0004, 16'h0, 2'd0, 1'b0, 1'b0);
        step("R7 seq c",      16'h0800, 16'h0800, 16'h0, 2'd0, 1'b0, 1'b0);
        // R8: reset in mid-run clears the output.
        rst_n = 1'b0;
        @(negedge clk);
        compare("R8 mid reset", -1);
        rst_n = 1'b1;

        // R4: random sweep over every level encoding against the reference.
        for (int k = 0; k < 4000; k++) begin
            step("R4 sweep", N'($urandom), N'($urandom), N'($urandom),
                 2'(k % 4), 1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule